// File: doc/BRIEF.md
# Bus-Cycle Strobe Sequencer

This block derives every timing strobe needed by a processor and a video DRAM that share a single memory bus. It is clocked at 24 MHz, twice the 12 MHz master rate, and steps a free-running phase counter through 24 positions, which is one 1 MHz processor cycle. Each position is decoded into a fixed pattern of levels. Every output is taken straight from a flip-flop, so no output can glitch.

Each processor cycle holds two DRAM accesses. The row and column strobes and the address-multiplexer selects therefore repeat every half cycle. The processor E and Q clocks, the upper multiplexer select and the data latch strobe repeat once per cycle. In the rest of this brief, a "step" is one period of `clk_i` and a "tick" is two steps, which is one 12 MHz period. Tick t spans steps 2t and 2t+1, and ticks are numbered 0 to 11 within a processor cycle.

Top module: `busphase_gen`

## Requirements
- R1: While `rst_i` is high at a rising edge, the sequencer is forced to step 0. The outputs then read clk12=0, clk6=0, E=0, Q=0, ras_n=0, cas_n=1, amux0=0, amux1=0, latch=0. The first rising edge after release advances to step 1.
- R2: The step counter counts 0 to 23 and wraps to 0. E is low for ticks 0 to 5 and high for ticks 6 to 11, so one E period is 24 steps.
- R3: `clk12_o` is low on even steps and high on odd steps. `clk6_o` is high exactly in odd ticks.
- R4: `q_o` has the period of E. It is high in ticks 3 to 8, which leads E by three ticks.
- R5: `ras_n_o` repeats every six ticks. Within each group of six it is low for the first four ticks and high for the last two.
- R6: `cas_n_o` repeats every six ticks. Within each group of six it is high in positions 0 and 1, low in positions 2 to 4, and high in position 5.
- R7: `amux0_o` repeats every six ticks. Within each group of six it is low in position 0, high in positions 1 to 4, and low in position 5.
- R8: `amux1_o` is high in ticks 5 to 10, so it rises one tick before E.
- R9: `latch_o` is high in ticks 7 to 10 and low everywhere else.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | 24 MHz reference clock |
| rst_i | input | 1 | Synchronous reset, active high |
| clk12_o | output | 1 | 12 MHz master clock level |
| clk6_o | output | 1 | 6 MHz clock level |
| e_o | output | 1 | Processor E clock |
| q_o | output | 1 | Processor Q clock (quadrature) |
| ras_n_o | output | 1 | DRAM row strobe, active low |
| cas_n_o | output | 1 | DRAM column strobe, active low |
| amux0_o | output | 1 | Address multiplexer select, low bit |
| amux1_o | output | 1 | Address multiplexer select, high bit |
| latch_o | output | 1 | Read data latch strobe |

## Verification
The bench checks every output at every step over many wraps of the counter. A counter that stopped at 24 or 31 instead of wrapping at 23 would stretch E and misplace every strobe after the first cycle. It looks closely at edges that are one tick apart: amux1 rising before E, and the column strobe falling only inside the row-strobe low window. An off-by-one decode would move these edges, or let the column strobe fall while the row strobe is high. It also applies a reset in the middle of a run and checks that the sequence restarts at step 0. A design that reset only the counter, or only the output registers, would present a shifted or stale pattern.

// File: rtl/busphase_pkg.sv
package busphase_pkg;

    typedef struct packed {
        logic clk12;
        logic clk6;
        logic e;
        logic q;
        logic ras_n;
        logic cas_n;
        logic amux0;
        logic amux1;
        logic latch;
    } strobes_t;

endpackage

// File: rtl/busphase_stepctr.sv
module busphase_stepctr #(
    parameter int unsigned STEPS = 24,
    localparam int unsigned W = $clog2(STEPS)
) (
    input  logic         clk_i,
    input  logic         rst_i,
    output logic [W-1:0] step_q_o,
    output logic [W-1:0] step_d_o
);
    localparam logic [W-1:0] LAST = W'(STEPS - 1);

    typedef struct packed {
        logic [W-1:0] step;
    } ctr_t;

    ctr_t ctr_d, ctr_q;

    always_comb begin
        ctr_d = ctr_q;
        if (rst_i || ctr_q.step == LAST) begin
            ctr_d.step = '0;
        end else begin
            ctr_d.step = ctr_q.step + W'(1);
        end
    end

    always_ff @(posedge clk_i) begin
        ctr_q <= ctr_d;
    end

    assign step_q_o = ctr_q.step;
    assign step_d_o = ctr_d.step;

    assert_step_range_R2: assert property (@(posedge clk_i) disable iff (rst_i)
        ctr_q.step <= LAST);

    assert_step_wrap_R2: assert property (@(posedge clk_i) disable iff (rst_i)
        (ctr_q.step == LAST) |=> (ctr_q.step == '0));

endmodule

// File: rtl/busphase_decode.sv
module busphase_decode
    import busphase_pkg::*;
#(
    parameter int unsigned STEPS_PER_TICK = 2,
    parameter int unsigned TICKS_PER_CPU  = 12,
    localparam int unsigned STEPS = STEPS_PER_TICK * TICKS_PER_CPU,
    localparam int unsigned W     = $clog2(STEPS)
) (
    input  logic [W-1:0] step_i,
    output strobes_t     strb_o
);
    localparam int unsigned HALF_TICKS = TICKS_PER_CPU / 2;
    localparam int unsigned QTR_TICKS  = TICKS_PER_CPU / 4;
    localparam int unsigned ACC_TICKS  = HALF_TICKS;
    localparam int unsigned RAS_LOW    = ACC_TICKS - 2;
    localparam int unsigned CAS_FIRST  = 2;
    localparam int unsigned CAS_LAST   = ACC_TICKS - 2;
    localparam int unsigned MUX0_FIRST = 1;
    localparam int unsigned MUX0_LAST  = ACC_TICKS - 2;
    localparam int unsigned MUX1_FIRST = HALF_TICKS - 1;
    localparam int unsigned LAT_FIRST  = HALF_TICKS + 1;
    localparam int unsigned LAT_LEN    = QTR_TICKS + 1;

    int unsigned tick;
    int unsigned sub;
    int unsigned slot;

    always_comb begin
        tick = 32'(step_i) / STEPS_PER_TICK;
        sub  = 32'(step_i) % STEPS_PER_TICK;
        slot = tick % ACC_TICKS;

        strb_o.clk12 = (sub >= STEPS_PER_TICK / 2);
        strb_o.clk6  = (tick % 2) == 1;
        strb_o.e     = (tick >= HALF_TICKS);
        strb_o.q     = (tick >= QTR_TICKS) && (tick < QTR_TICKS + HALF_TICKS);
        strb_o.ras_n = (slot >= RAS_LOW);
        strb_o.cas_n = !((slot >= CAS_FIRST) && (slot <= CAS_LAST));
        strb_o.amux0 = (slot >= MUX0_FIRST) && (slot <= MUX0_LAST);
        strb_o.amux1 = (tick >= MUX1_FIRST) && (tick < MUX1_FIRST + HALF_TICKS);
        strb_o.latch = (tick >= LAT_FIRST) && (tick < LAT_FIRST + LAT_LEN);
    end

endmodule

// File: rtl/busphase_gen.sv
module busphase_gen
    import busphase_pkg::*;
#(
    parameter int unsigned STEPS_PER_TICK = 2,
    parameter int unsigned TICKS_PER_CPU  = 12,
    localparam int unsigned STEPS = STEPS_PER_TICK * TICKS_PER_CPU,
    localparam int unsigned W     = $clog2(STEPS)
) (
    input  logic clk_i,
    input  logic rst_i,
    output logic clk12_o,
    output logic clk6_o,
    output logic e_o,
    output logic q_o,
    output logic ras_n_o,
    output logic cas_n_o,
    output logic amux0_o,
    output logic amux1_o,
    output logic latch_o
);
    typedef struct packed {
        strobes_t strb;
        logic     live;
    } state_t;

    logic [W-1:0] step_q;
    logic [W-1:0] step_d;
    strobes_t     dec_strb;
    state_t       state_d, state_q;

    busphase_stepctr #(.STEPS(STEPS)) u_ctr (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .step_q_o (step_q),
        .step_d_o (step_d)
    );

    busphase_decode #(
        .STEPS_PER_TICK (STEPS_PER_TICK),
        .TICKS_PER_CPU  (TICKS_PER_CPU)
    ) u_dec (
        .step_i (step_d),
        .strb_o (dec_strb)
    );

    always_comb begin
        state_d      = state_q;
        state_d.strb = dec_strb;
        state_d.live = !rst_i;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            state_q.live <= 1'b0;
            state_q.strb <= state_d.strb;
        end else begin
            state_q <= state_d;
        end
    end

    assign clk12_o = state_q.strb.clk12;
    assign clk6_o  = state_q.strb.clk6;
    assign e_o     = state_q.strb.e;
    assign q_o     = state_q.strb.q;
    assign ras_n_o = state_q.strb.ras_n;
    assign cas_n_o = state_q.strb.cas_n;
    assign amux0_o = state_q.strb.amux0;
    assign amux1_o = state_q.strb.amux1;
    assign latch_o = state_q.strb.latch;

    assert_clk12_toggles_R3: assert property (@(posedge clk_i) disable iff (rst_i)
        state_q.live |-> (clk12_o != $past(clk12_o)));

    assert_step_tracks_E_R2: assert property (@(posedge clk_i) disable iff (rst_i)
        state_q.live |-> (e_o == (step_q >= W'(STEPS / 2))));

    assert_q_rises_in_e_low_R4: assert property (@(posedge clk_i) disable iff (rst_i)
        (state_q.live && $rose(q_o)) |-> !e_o);

    assert_e_rises_in_q_high_R4: assert property (@(posedge clk_i) disable iff (rst_i)
        (state_q.live && $rose(e_o)) |-> q_o);

    assert_cas_inside_ras_R6: assert property (@(posedge clk_i) disable iff (rst_i)
        (state_q.live && $fell(cas_n_o)) |-> !ras_n_o);

    assert_mux1_leads_e_R8: assert property (@(posedge clk_i) disable iff (rst_i)
        (state_q.live && $rose(amux1_o)) |-> ##2 $rose(e_o));

    assert_latch_window_R9: assert property (@(posedge clk_i) disable iff (rst_i)
        latch_o |-> (e_o && amux1_o));

endmodule

// File: tb/tb_busphase_gen.sv
module tb_busphase_gen;

    typedef struct packed {
        bit c12;
        bit c6;
        bit e;
        bit q;
        bit ras_n;
        bit cas_n;
        bit m0;
        bit m1;
        bit lt;
    } exp_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic clk12, clk6, e, q, ras_n, cas_n, amux0, amux1, latch;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;
    exp_t sb[$];

    always #4 clk = ~clk;

    busphase_gen dut (
        .clk_i   (clk),
        .rst_i   (rst),
        .clk12_o (clk12),
        .clk6_o  (clk6),
        .e_o     (e),
        .q_o     (q),
        .ras_n_o (ras_n),
        .cas_n_o (cas_n),
        .amux0_o (amux0),
        .amux1_o (amux1),
        .latch_o (latch)
    );

    function automatic exp_t model(int s);
        exp_t x;
        int c = s / 2;
        int g = c % 6;
        x.c12   = (s % 2) == 1;          // R3
        x.c6    = (c % 2) == 1;          // R3
        x.e     = c >= 6;                // R2
        x.q     = c inside {[3:8]};      // R4
        x.ras_n = g inside {4, 5};       // R5
        x.cas_n = g inside {0, 1, 5};    // R6
        x.m0    = g inside {[1:4]};      // R7
        x.m1    = c inside {[5:10]};     // R8
        x.lt    = c inside {[7:10]};     // R9
        return x;
    endfunction

    task automatic chk(bit act, bit exp, string req, string what);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0b expected %0b at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic compare(exp_t x, string tag);
        chk(clk12, x.c12,   "R3", {tag, " clk12"});
        chk(clk6,  x.c6,    "R3", {tag, " clk6"});
        chk(e,     x.e,     "R2", {tag, " E"});
        chk(q,     x.q,     "R4", {tag, " Q"});
        chk(ras_n, x.ras_n, "R5", {tag, " ras_n"});
        chk(cas_n, x.cas_n, "R6", {tag, " cas_n"});
        chk(amux0, x.m0,    "R7", {tag, " amux0"});
        chk(amux1, x.m1,    "R8", {tag, " amux1"});
        chk(latch, x.lt,    "R9", {tag, " latch"});
    endtask

    // R1: step-0 pattern held during reset
    task automatic check_reset_state();
        exp_t z;
        z = '{c12:0, c6:0, e:0, q:0, ras_n:0, cas_n:1, m0:0, m1:0, lt:0};
        chk(clk12, z.c12,   "R1", "reset clk12");
        chk(clk6,  z.c6,    "R1", "reset clk6");
        chk(e,     z.e,     "R1", "reset E");
        chk(q,     z.q,     "R1", "reset Q");
        chk(ras_n, z.ras_n, "R1", "reset ras_n");
        chk(cas_n, z.cas_n, "R1", "reset cas_n");
        chk(amux0, z.m0,    "R1", "reset amux0");
        chk(amux1, z.m1,    "R1", "reset amux1");
        chk(latch, z.lt,    "R1", "reset latch");
    endtask

    // Driver: push expected steps 1..n (mod 24) after a release
    task automatic push_run(int n);
        for (int k = 1; k <= n; k++) begin
            sb.push_back(model(k % 24));
        end
    endtask

    // Monitor: compare one scoreboard item per step, away from the edge
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (sb.size() > 0) begin
                exp_t x;
                x = sb.pop_front();
                compare(x, "seq");
            end
        end
    end

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (3000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check_reset_state();                 // R1 at power-up
        @(negedge clk);
        rst = 1'b0;
        push_run(24 * 5);                    // R2..R9 over five E periods
        wait (sb.size() == 0);
        @(negedge clk);
        @(negedge clk);
        rst = 1'b1;                          // R1 mid-run reset
        repeat (3) @(negedge clk);
        check_reset_state();
        rst = 1'b0;
        push_run(24 * 3 + 7);                // R1: restart from step 1
        wait (sb.size() == 0);
        @(negedge clk);
        done = 1'b1;
        finish_run();
    end

endmodule